// File: doc/BRIEF.md
# Watchdog Start-Up Window and Configuration Lock

This block governs the opening phase of a watchdog. It waits in an idle state until the chip's reset output is released. It then runs an initial long window whose length comes from an 8-bit code held in a host-writable register. During that window the host may program the full watchdog setup: enable, operating mode, window-1 and window-2 lengths, reset enable, fail and reset thresholds, and the three question-generator settings (feedback, LFSR and seed). The host may also write the power-hold, return-to-window and drive-request bits.

When the window ends, the protected fields freeze and a one-cycle pulse tells the sequence engine to begin its first sequence. If the host clears enable during the window, the watchdog drops into a disabled state. In that state the host may drive the output-enable control, as long as no other error is flagged. The host re-arms the watchdog by setting enable again, which is accepted only once power-hold has already been cleared.

Durations are counted in ticks of a 1 ms strobe. The code has three segments. Code 0 gives a short fixed interval. Codes 1 to 64 count in 125 ms units. Codes 65 to 255 count in 4 s units, starting at 12 s. Configuration survives everything except the power-on reset.

Top module: `wdg_lw_ctrl`

## Requirements
- R1: After rst_n, the block is idle with lw_active, wd_disabled, cfg_locked, seq_start, drv_en and wr_rejected all 0. cfg_enable is 1, cfg_lw_code equals LW_CODE_RST (default 0x00), and every other field is 0.
- R2: A long window starts on the first clock edge that samples rstout_rel high in the idle state. The window lasts exactly as many tick_ms pulses as the code selects. Code 0x00 gives T80 ticks (80).
- R3: Codes 0x01 to 0x40 give code × T125 ticks (125 ms steps).
- R4: Codes 0x41 to 0xFF give (code − 62) × T4S ticks, which is 12 s plus (code − 0x41) × 4 s.
- R5: The clock edge that samples the final tick moves the block into the running state. From the next sample onward, cfg_locked is 1 and seq_start is 1 for exactly one cycle. The running state is kept until rst_n.
- R6: Writes take effect in the long window and in the disabled state. Address 0 holds: bit0 enable, bit1 mode, bit2 hold, bit3 return-to-window, bit4 reset enable, bits7:5 fail threshold, bits10:8 reset threshold, bit11 drive request. Address 1 holds the window code in bits7:0. Address 2 holds window-1 in bits6:0 and window-2 in bits14:8. Address 3 holds feedback in bits1:0, LFSR in bits3:2 and seed in bits7:4.
- R7: In the idle and running states, writes to addresses 1 to 3 and to the protected bits of address 0 are ignored, and wr_rejected is set and stays set. The protected bits of address 0 are enable, mode, reset enable and both thresholds. The hold, return-to-window and drive-request bits remain writable in every state.
- R8: If enable is 0 in the long window, the next clock edge enters the disabled state (wd_disabled=1, lw_active=0). Ticks then never start a sequence.
- R9: In the disabled state, a write of enable=1 is accepted only when the stored hold bit is already 0. The long window then restarts with a full count. Otherwise enable stays 0 and wr_rejected is set.
- R10: drv_en is 1 exactly when the block is disabled, the drive-request bit is 1 and err_other is 0.
- R11: Only tick_ms pulses advance the window. With tick_ms held low, the window never ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| tick_ms | input | 1 | One-cycle 1 ms time strobe |
| rstout_rel | input | 1 | Reset output has been released |
| err_other | input | 1 | Another error flag is set |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write word address |
| wr_data | input | 16 | Host write data |
| lw_active | output | 1 | Long window running |
| wd_disabled | output | 1 | Watchdog disabled by the host |
| cfg_locked | output | 1 | Protected fields frozen, sequences running |
| seq_start | output | 1 | One-cycle pulse to start the first sequence |
| drv_en | output | 1 | Output-enable control while disabled |
| wr_rejected | output | 1 | Sticky: a write was refused |
| cfg_enable | output | 1 | Enable bit |
| cfg_mode | output | 1 | Mode select |
| cfg_hold | output | 1 | Power-hold bit |
| cfg_ret_long | output | 1 | Return-to-window bit |
| cfg_rst_en | output | 1 | Reset enable |
| cfg_fail_th | output | 3 | Fail threshold |
| cfg_rst_th | output | 3 | Reset threshold |
| cfg_lw_code | output | 8 | Long-window code |
| cfg_win1 | output | 7 | Window-1 length |
| cfg_win2 | output | 7 | Window-2 length |
| cfg_fdbk | output | 2 | Answer feedback setting |
| cfg_lfsr | output | 2 | Question LFSR setting |
| cfg_seed | output | 4 | Question seed |

## Verification
The bench measures the window length at the edges of each code segment: 0x00, 0x01, 0x40, 0x41 and 0xFF, plus values inside the segments. A decoder that shifts a segment boundary by one, or gets the 12 s offset wrong, gives a different tick count. The bench also tries a re-enable while hold is still set, which a careless design would accept. It writes protected fields after the lock and before release, where a leaky gate would change a field or leave the sticky flag clear. It re-enters the window after a disable to catch a tick counter that is not cleared, which would cut the restarted window short. Finally, it toggles err_other while disabled to expose a drive output that ignores the error gate.

// File: rtl/wdg_lw_pkg.sv
package wdg_lw_pkg;

  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_WIN  = 2'd2;
  localparam logic [ADDR_W-1:0] A_QA   = 2'd3;

  // protected bits of the control word: enable, mode, reset enable, thresholds
  localparam logic [10:0] CTRL_LOCK_MASK = 11'h7F3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LW   = 2'd1,
    ST_DIS  = 2'd2,
    ST_RUN  = 2'd3
  } wd_state_e;

  typedef struct packed {
    logic       en;
    logic       mode;
    logic       hold;
    logic       ret_long;
    logic       rst_en;
    logic [2:0] fail_th;
    logic [2:0] rst_th;
    logic       drv_req;
    logic [7:0] lw_code;
    logic [6:0] win1;
    logic [6:0] win2;
    logic [1:0] fdbk;
    logic [1:0] lfsr;
    logic [3:0] seed;
  } wd_cfg_t;

endpackage

// File: rtl/wdg_lw_decode.sv
module wdg_lw_decode #(
  parameter int T80  = 80,
  parameter int T125 = 125,
  parameter int T4S  = 4000,
  parameter int CW   = 20
) (
  input  logic [7:0]    code,
  output logic [CW-1:0] dur
);

  localparam logic [7:0] SEG2_LAST = 8'h40;
  localparam int         SEG3_BIAS = 62;

  always_comb begin
    if (code == 8'h00) begin
      dur = CW'(T80);
    end else if (code <= SEG2_LAST) begin
      dur = CW'(code) * CW'(T125);
    end else begin
      dur = (CW'(code) - CW'(SEG3_BIAS)) * CW'(T4S);
    end
  end

  // R2 R3 R4: every code yields a non-empty window
  always_comb begin
    dur_nonzero_chk: assert (dur != '0);
  end

endmodule

// File: rtl/wdg_lw_timer.sv
module wdg_lw_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lw_act,
  input  logic          tick,
  input  logic [CW-1:0] dur,
  output logic          expire
);

  logic [CW-1:0] elapsed_q;
  logic [CW-1:0] elapsed_d;
  logic [CW-1:0] elapsed_inc;

  assign elapsed_inc = elapsed_q + CW'(1);
  assign expire      = lw_act && tick && (elapsed_inc >= dur);

  always_comb begin
    elapsed_d = elapsed_q;
    if (!lw_act) begin
      elapsed_d = '0;
    end else if (tick && !expire) begin
      elapsed_d = elapsed_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else begin
      elapsed_q <= elapsed_d;
    end
  end

  // R2: the count restarts from zero on every entry into the window
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lw_act |=> elapsed_q == '0);

  // R11: the count only moves on a tick
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_act && !tick) |=> $stable(elapsed_q));

endmodule

// File: rtl/wdg_lw_cfg.sv
module wdg_lw_cfg
  import wdg_lw_pkg::*;
#(
  parameter logic [7:0] LW_CODE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wd_state_e         st,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wd_cfg_t           cfg,
  output logic              wr_rej
);

  wd_cfg_t     cfg_q;
  wd_cfg_t     cfg_d;
  logic        rej_q;
  logic        rej_d;
  logic        open_w;
  logic [10:0] ctrl_now;
  logic        unused_data;

  assign unused_data = wr_data[15];
  assign open_w      = (st == ST_LW) || (st == ST_DIS);
  assign ctrl_now    = {cfg_q.drv_req, cfg_q.rst_th, cfg_q.fail_th, cfg_q.rst_en,
                        cfg_q.ret_long, cfg_q.hold, cfg_q.mode, cfg_q.en};

  always_comb begin
    cfg_d = cfg_q;
    rej_d = rej_q;
    if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          cfg_d.hold     = wr_data[2];
          cfg_d.ret_long = wr_data[3];
          cfg_d.drv_req  = wr_data[11];
          if (open_w) begin
            cfg_d.mode    = wr_data[1];
            cfg_d.rst_en  = wr_data[4];
            cfg_d.fail_th = wr_data[7:5];
            cfg_d.rst_th  = wr_data[10:8];
            if ((st == ST_DIS) && wr_data[0] && cfg_q.hold) begin
              rej_d = 1'b1;
            end else begin
              cfg_d.en = wr_data[0];
            end
          end else if ((wr_data[10:0] & CTRL_LOCK_MASK) != (ctrl_now & CTRL_LOCK_MASK)) begin
            rej_d = 1'b1;
          end
        end
        A_CODE: begin
          if (open_w) cfg_d.lw_code = wr_data[7:0];
          else        rej_d = 1'b1;
        end
        A_WIN: begin
          if (open_w) begin
            cfg_d.win1 = wr_data[6:0];
            cfg_d.win2 = wr_data[14:8];
          end else begin
            rej_d = 1'b1;
          end
        end
        A_QA: begin
          if (open_w) begin
            cfg_d.fdbk = wr_data[1:0];
            cfg_d.lfsr = wr_data[3:2];
            cfg_d.seed = wr_data[7:4];
          end else begin
            rej_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q         <= '0;
      cfg_q.en      <= 1'b1;
      cfg_q.lw_code <= LW_CODE_RST;
      rej_q         <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      rej_q <= rej_d;
    end
  end

  assign cfg    = cfg_q;
  assign wr_rej = rej_q;

  // R7
  lock_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_w |=> ($stable(cfg_q.win1) && $stable(cfg_q.win2) && $stable(cfg_q.lw_code)
                 && $stable(cfg_q.seed) && $stable(cfg_q.en) && $stable(cfg_q.fail_th)));

  // R7
  rej_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |=> rej_q);

  // R9
  hold_blocks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIS && cfg_q.hold && !cfg_q.en) |=> !cfg_q.en);

endmodule

// File: rtl/wdg_lw_ctrl.sv
module wdg_lw_ctrl
  import wdg_lw_pkg::*;
#(
  parameter int         T80         = 80,
  parameter int         T125        = 125,
  parameter int         T4S         = 4000,
  parameter logic [7:0] LW_CODE_RST = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_ms,
  input  logic        rstout_rel,
  input  logic        err_other,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic        lw_active,
  output logic        wd_disabled,
  output logic        cfg_locked,
  output logic        seq_start,
  output logic        drv_en,
  output logic        wr_rejected,
  output logic        cfg_enable,
  output logic        cfg_mode,
  output logic        cfg_hold,
  output logic        cfg_ret_long,
  output logic        cfg_rst_en,
  output logic [2:0]  cfg_fail_th,
  output logic [2:0]  cfg_rst_th,
  output logic [7:0]  cfg_lw_code,
  output logic [6:0]  cfg_win1,
  output logic [6:0]  cfg_win2,
  output logic [1:0]  cfg_fdbk,
  output logic [1:0]  cfg_lfsr,
  output logic [3:0]  cfg_seed
);

  localparam int MAX_A  = (T80 > 64 * T125) ? T80 : 64 * T125;
  localparam int MAX_T  = (MAX_A > 193 * T4S) ? MAX_A : 193 * T4S;
  localparam int CW     = $clog2(MAX_T + 1);

  wd_state_e     st_q;
  wd_state_e     st_d;
  wd_cfg_t       cfg;
  logic [CW-1:0] dur;
  logic          expire;
  logic          start_q;
  logic          start_d;

  wdg_lw_cfg #(.LW_CODE_RST(LW_CODE_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .wr_rej  (wr_rejected)
  );

  wdg_lw_decode #(.T80(T80), .T125(T125), .T4S(T4S), .CW(CW)) u_dec (
    .code (cfg.lw_code),
    .dur  (dur)
  );

  wdg_lw_timer #(.CW(CW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lw_act (st_q == ST_LW),
    .tick   (tick_ms),
    .dur    (dur),
    .expire (expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (rstout_rel) st_d = ST_LW;
      ST_LW: begin
        if (!cfg.en)     st_d = ST_DIS;
        else if (expire) st_d = ST_RUN;
      end
      ST_DIS:  if (cfg.en) st_d = ST_LW;
      ST_RUN:  st_d = ST_RUN;
      default: st_d = ST_IDLE;
    endcase
    start_d = (st_q == ST_LW) && (st_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
    end
  end

  assign lw_active    = (st_q == ST_LW);
  assign wd_disabled  = (st_q == ST_DIS);
  assign cfg_locked   = (st_q == ST_RUN);
  assign seq_start    = start_q;
  assign drv_en       = wd_disabled && cfg.drv_req && !err_other;

  assign cfg_enable   = cfg.en;
  assign cfg_mode     = cfg.mode;
  assign cfg_hold     = cfg.hold;
  assign cfg_ret_long = cfg.ret_long;
  assign cfg_rst_en   = cfg.rst_en;
  assign cfg_fail_th  = cfg.fail_th;
  assign cfg_rst_th   = cfg.rst_th;
  assign cfg_lw_code  = cfg.lw_code;
  assign cfg_win1     = cfg.win1;
  assign cfg_win2     = cfg.win2;
  assign cfg_fdbk     = cfg.fdbk;
  assign cfg_lfsr     = cfg.lfsr;
  assign cfg_seed     = cfg.seed;

  // R5
  run_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> (st_q == ST_RUN));

  // R5
  start_from_lw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_locked) |-> (seq_start && $past(lw_active)));

  // R8
  dis_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DIS && !cfg.en) |=> (st_q == ST_DIS));

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start);

endmodule

// File: tb/wdg_lw_ctrl_tb.sv
module wdg_lw_ctrl_tb;

  localparam int T80  = 4;
  localparam int T125 = 5;
  localparam int T4S  = 40;
  localparam int NV   = 8;
  localparam int VCODE [NV] = '{8'h00, 8'h01, 8'h02, 8'h40, 8'h41, 8'h42, 8'h80, 8'hFF};
  localparam int VEXP  [NV] = '{T80, T125, 2*T125, 64*T125, 3*T4S, 4*T4S, 66*T4S, 193*T4S};

  logic clk = 1'b0;
  logic rst_n, tick_ms, rstout_rel, err_other, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic lw_active, wd_disabled, cfg_locked, seq_start, drv_en, wr_rejected;
  logic cfg_enable, cfg_mode, cfg_hold, cfg_ret_long, cfg_rst_en;
  logic [2:0] cfg_fail_th, cfg_rst_th;
  logic [7:0] cfg_lw_code;
  logic [6:0] cfg_win1, cfg_win2;
  logic [1:0] cfg_fdbk, cfg_lfsr;
  logic [3:0] cfg_seed;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  wdg_lw_ctrl #(.T80(T80), .T125(T125), .T4S(T4S)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rstout_rel(rstout_rel),
    .err_other(err_other), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lw_active(lw_active), .wd_disabled(wd_disabled), .cfg_locked(cfg_locked),
    .seq_start(seq_start), .drv_en(drv_en), .wr_rejected(wr_rejected),
    .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_hold(cfg_hold),
    .cfg_ret_long(cfg_ret_long), .cfg_rst_en(cfg_rst_en), .cfg_fail_th(cfg_fail_th),
    .cfg_rst_th(cfg_rst_th), .cfg_lw_code(cfg_lw_code), .cfg_win1(cfg_win1),
    .cfg_win2(cfg_win2), .cfg_fdbk(cfg_fdbk), .cfg_lfsr(cfg_lfsr), .cfg_seed(cfg_seed)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rstout_rel = 1'b0; tick_ms = 1'b0; err_other = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (!lw_active || n >= 20000) break;
    end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int n;
    string tag;

    // table of codes and expected window lengths
    for (int i = 0; i < NV; i++) begin
      do_reset();
      rstout_rel = 1'b1;
      @(negedge clk);
      wr(2'd1, 16'(VCODE[i]));
      tick_ms = 1'b1;
      measure(n);
      tag = (VCODE[i] == 0) ? "R2" : ((VCODE[i] <= 64) ? "R3" : "R4");
      chk(tag, n, VEXP[i]);
      chk("R5 seq_start", int'(seq_start), 1);
      chk("R5 locked", int'(cfg_locked), 1);
      @(negedge clk);
      chk("R5 pulse ends", int'(seq_start), 0);
      chk("R5 stays run", int'(cfg_locked), 1);
    end

    // R1: reset state
    do_reset();
    chk("R1 lw_active", int'(lw_active), 0);
    chk("R1 locked", int'(cfg_locked), 0);
    chk("R1 disabled", int'(wd_disabled), 0);
    chk("R1 enable", int'(cfg_enable), 1);
    chk("R1 code", int'(cfg_lw_code), 0);
    chk("R1 rejected", int'(wr_rejected), 0);
    chk("R1 drv_en", int'(drv_en), 0);
    // R7: idle writes to protected fields are refused
    wr(2'd2, 16'h1111);
    chk("R7 idle win1", int'(cfg_win1), 0);
    chk("R7 idle rej", int'(wr_rejected), 1);

    // R6 / R11 / R7
    do_reset();
    chk("R1 rej cleared", int'(wr_rejected), 0);
    rstout_rel = 1'b1;
    @(negedge clk);
    repeat (50) @(negedge clk);
    chk("R11 no tick", int'(lw_active), 1);
    wr(2'd2, 16'h552A);
    wr(2'd3, 16'h00B6);
    wr(2'd0, 16'h06BB);
    chk("R6 win1", int'(cfg_win1), 8'h2A);
    chk("R6 win2", int'(cfg_win2), 8'h55);
    chk("R6 fdbk", int'(cfg_fdbk), 2);
    chk("R6 lfsr", int'(cfg_lfsr), 1);
    chk("R6 seed", int'(cfg_seed), 11);
    chk("R6 mode", int'(cfg_mode), 1);
    chk("R6 ret", int'(cfg_ret_long), 1);
    chk("R6 rst_en", int'(cfg_rst_en), 1);
    chk("R6 fail", int'(cfg_fail_th), 5);
    chk("R6 rst_th", int'(cfg_rst_th), 6);
    chk("R6 rej", int'(wr_rejected), 0);
    wr(2'd1, 16'h0001);
    tick_ms = 1'b1;
    measure(n);
    chk("R3 after cfg", n, T125);
    wr(2'd2, 16'h0000);
    chk("R7 win1 locked", int'(cfg_win1), 8'h2A);
    chk("R7 rej", int'(wr_rejected), 1);
    wr(2'd0, 16'h00B6);
    chk("R7 enable locked", int'(cfg_enable), 1);
    chk("R7 fail locked", int'(cfg_fail_th), 5);
    chk("R7 hold writable", int'(cfg_hold), 1);
    chk("R7 ret writable", int'(cfg_ret_long), 0);

    // R8 / R10 / R9
    do_reset();
    rstout_rel = 1'b1;
    @(negedge clk);
    wr(2'd0, 16'h0005);
    wr(2'd0, 16'h0004);
    @(negedge clk);
    chk("R8 disabled", int'(wd_disabled), 1);
    chk("R8 lw off", int'(lw_active), 0);
    tick_ms = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 no start", int'(cfg_locked), 0);
    chk("R8 still dis", int'(wd_disabled), 1);
    wr(2'd0, 16'h0804);
    chk("R10 drv on", int'(drv_en), 1);
    err_other = 1'b1;
    @(negedge clk);
    chk("R10 err gate", int'(drv_en), 0);
    err_other = 1'b0;
    wr(2'd0, 16'h0805);
    @(negedge clk);
    chk("R9 en refused", int'(cfg_enable), 0);
    chk("R9 still dis", int'(wd_disabled), 1);
    chk("R9 rej", int'(wr_rejected), 1);
    wr(2'd0, 16'h0800);
    wr(2'd0, 16'h0801);
    @(negedge clk);
    chk("R9 re-armed", int'(lw_active), 1);
    chk("R10 drv off", int'(drv_en), 0);
    measure(n);
    chk("R9 full window", n, T80);
    chk("R5 after rearm", int'(cfg_locked), 1);

    summary();
  end

endmodule